// File: doc/BRIEF.md
# Pin Input Conditioner and Interrupt Detector

This block conditions a bank of asynchronous general-purpose pin inputs and turns their activity into interrupts. Each pin passes through two synchronizer stages. Software can set either stage to pass the signal straight through, to sample it on the falling clock edge, or to sample it on the rising clock edge. The conditioned value of every pin can be read back. A per-pin trigger field selects rising, falling or any-edge detection, or low-level or high-level detection. A detected condition sets that pin's sticky status bit.

Software owns the status vector through a direct write port and two write-one aliases, one that sets bits and one that clears them. The current detections appear as a raw event vector. Each status bit is gated by a per-pin interrupt enable to form a CPU interrupt vector, and all of those bits are ORed into one interrupt line. A per-pin wake enable lets a pin's live detection drive a wake request.

The register port is a single-cycle word interface. Writes take effect at the rising edge on which `reg_wr` is high. Reads are combinational from `reg_addr`.

Top module: `pin_event_unit`

## Requirements
- R1: After a synchronous active-low reset, every pin configuration word, every status bit, the raw event vector, the CPU interrupt vector, `irq` and `wake_req` are 0. Configuration 0 bypasses both synchronizer stages.
- R2: Configuration bits [1:0] set the first synchronizer stage and bits [3:2] set the second. Mode 0 passes the input straight through, mode 1 samples it on the falling clock edge, and modes 2 and 3 sample it on the rising clock edge. The conditioned value is the output of the second stage.
- R3: Word address 0 reads the conditioned value of pin n in bit n.
- R4: Configuration bits [6:4] hold the trigger type. Type 1 detects a rising edge, type 2 a falling edge and type 3 either edge. An edge is a difference between the conditioned value and its copy registered at the previous rising clock edge.
- R5: Trigger type 4 detects a low level and type 5 a high level. The status bit is set again on every cycle the level holds, so a clear does not stick while the level remains.
- R6: Trigger types 0, 6 and 7 never produce a detection and never set the status bit.
- R7: The raw event vector shows the current detections. It is available on `raw_event` and at word address 4.
- R8: The status vector is read at word address 1, and writing to that address replaces it. Writing to word address 2 sets every status bit whose data bit is 1. Writing to word address 3 clears every status bit whose data bit is 1. Bits written as 0 are unchanged. A detection sets the status bit at the next rising edge.
- R9: When a detection and a software clear or direct write of 0 reach the same status bit in the same cycle, the bit ends up 1.
- R10: Configuration bit [7] is the pin's interrupt enable. Bit n of `cpu_int`, and of word address 5, is status bit n AND that enable. `irq` is the OR of all `cpu_int` bits.
- R11: Configuration bit [8] is the pin's wake enable. `wake_req` is high whenever any pin has both a live detection and its wake enable set.
- R12: The configuration word of pin n is at word address 8+n. It reads back the 9 bits that were written, with zeros above them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; both edges are used by the synchronizer stages |
| rst_n | input | 1 | Synchronous active-low reset |
| pins_in | input | NPINS | Asynchronous pin inputs |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Word address for read and write |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Combinational read data |
| raw_event | output | NPINS | Live detection per pin |
| cpu_int | output | NPINS | Status gated by the per-pin interrupt enable |
| irq | output | 1 | OR of all CPU interrupt bits |
| wake_req | output | 1 | OR of live detections on wake-enabled pins |

## Verification
A hardware detection and a software clear can reach the same status bit on the same rising edge, and the clear must lose. The bench sets a pin's status bit, then in one cycle raises that pin's input under a bypassed rising-edge trigger and writes the clear alias for the same bit. After that edge it expects the bit to read 1. A second case pairs a falling edge with a direct write of 0 to the status word and expects the same result. A held low level under the level trigger is cleared by software while the level is still present, and the bench expects the bit to stay set.

// File: rtl/pin_event_pkg.sv
// Shared types and register map for the pin conditioner and interrupt detector.
// Assumes word addressing; configuration words start at CFG_BASE.
package pin_event_pkg;

    typedef enum logic [1:0] {
        SYNC_BYPASS   = 2'd0,
        SYNC_FALL     = 2'd1,
        SYNC_RISE     = 2'd2,
        SYNC_RISE_ALT = 2'd3
    } sync_mode_e;

    typedef enum logic [2:0] {
        TRIG_OFF   = 3'd0,
        TRIG_RISE  = 3'd1,
        TRIG_FALL  = 3'd2,
        TRIG_ANY   = 3'd3,
        TRIG_LOW   = 3'd4,
        TRIG_HIGH  = 3'd5,
        TRIG_RSV6  = 3'd6,
        TRIG_RSV7  = 3'd7
    } trig_e;

    // Packed MSB first: wake_en[8], int_en[7], trig[6:4], stage2[3:2], stage1[1:0]
    typedef struct packed {
        logic       wake_en;
        logic       int_en;
        trig_e      trig;
        sync_mode_e stage2;
        sync_mode_e stage1;
    } pin_cfg_t;

    localparam int CFG_W = $bits(pin_cfg_t);

    localparam int ADDR_IN       = 0;
    localparam int ADDR_STATUS   = 1;
    localparam int ADDR_STAT_SET = 2;
    localparam int ADDR_STAT_CLR = 3;
    localparam int ADDR_RAW      = 4;
    localparam int ADDR_CPU_INT  = 5;
    localparam int CFG_BASE      = 8;

    // Detection for one pin from its current and previous conditioned value
    function automatic logic trig_hit(input trig_e t, input logic cur, input logic prev);
        logic hit;
        case (t)
            TRIG_RISE: hit = cur & ~prev;
            TRIG_FALL: hit = ~cur & prev;
            TRIG_ANY:  hit = cur ^ prev;
            TRIG_LOW:  hit = ~cur;
            TRIG_HIGH: hit = cur;
            default:   hit = 1'b0;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/pin_sync_stage.sv
// One synchronizer stage for one pin.
// Two flops run at all times, one on each clock edge, and the mode picks the
// flop or passes the input straight through. Assumes the mode is quasi-static.
module pin_sync_stage
    import pin_event_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  sync_mode_e mode,
    input  logic       d,
    output logic       q
);

    logic q_fall;
    logic q_rise;

    // Falling-edge sample of the stage input
    always_ff @(negedge clk) begin
        if (!rst_n) q_fall <= 1'b0;
        else        q_fall <= d;
    end

    // Rising-edge sample of the stage input
    always_ff @(posedge clk) begin
        if (!rst_n) q_rise <= 1'b0;
        else        q_rise <= d;
    end

    // Stage output selection by mode
    always_comb begin
        case (mode)
            SYNC_BYPASS: q = d;
            SYNC_FALL:   q = q_fall;
            default:     q = q_rise;
        endcase
    end

    // R2
    rise_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && mode[1]) |-> (q == $past(d)));

    // R2
    fall_sample_chk: assert property (@(negedge clk) disable iff (!rst_n)
        ($past(rst_n) && mode == SYNC_FALL) |-> (q == $past(d)));

endmodule

// File: rtl/pin_detector.sv
// Trigger detection and sticky status bit for one pin.
// Assumes at most one of sw_wr, sw_set and sw_clr is high per cycle.
// A detection overrides any software action on the same edge.
module pin_detector
    import pin_event_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  trig_e trig,
    input  logic  cur,
    input  logic  sw_wr,
    input  logic  sw_wr_val,
    input  logic  sw_set,
    input  logic  sw_clr,
    output logic  raw,
    output logic  stat
);

    logic prev;
    logic stat_next;

    // Previous-cycle copy of the conditioned value for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= 1'b0;
        else        prev <= cur;
    end

    // Live detection for the configured trigger
    always_comb raw = trig_hit(trig, cur, prev);

    // Status next-state: software action first, detection last so it wins
    always_comb begin
        stat_next = stat;
        if (sw_wr)  stat_next = sw_wr_val;
        if (sw_set) stat_next = 1'b1;
        if (sw_clr) stat_next = 1'b0;
        if (raw)    stat_next = 1'b1;
    end

    // Sticky status register
    always_ff @(posedge clk) begin
        if (!rst_n) stat <= 1'b0;
        else        stat <= stat_next;
    end

    // R9
    event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        raw |=> stat);

    // R8
    sw_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_clr && !raw) |=> !stat);

    // R8
    sw_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sw_set |=> stat);

    // R6
    reserved_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trig == TRIG_OFF || trig == TRIG_RSV6 || trig == TRIG_RSV7) |-> !raw);

    // R5
    level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((trig == TRIG_HIGH && cur) || (trig == TRIG_LOW && !cur)) |-> raw);

endmodule

// File: rtl/pin_event_regs.sv
// Register decode, per-pin configuration storage and read multiplexer.
// Assumes single-cycle writes and combinational reads on a word address.
module pin_event_regs
    import pin_event_pkg::*;
#(
    parameter int NPINS  = 8,
    parameter int ADDR_W = 5,
    parameter int DATA_W = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [DATA_W-1:0]       wdata,
    input  logic [NPINS-1:0]        in_val,
    input  logic [NPINS-1:0]        status,
    input  logic [NPINS-1:0]        raw,
    input  logic [NPINS-1:0]        cpu_int,
    output logic [NPINS*CFG_W-1:0]  cfg_flat,
    output logic                    stat_wr,
    output logic                    stat_set,
    output logic                    stat_clr,
    output logic [DATA_W-1:0]       rdata
);

    localparam logic [ADDR_W-1:0] A_IN   = ADDR_W'(ADDR_IN);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(ADDR_STATUS);
    localparam logic [ADDR_W-1:0] A_SET  = ADDR_W'(ADDR_STAT_SET);
    localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(ADDR_STAT_CLR);
    localparam logic [ADDR_W-1:0] A_RAW  = ADDR_W'(ADDR_RAW);
    localparam logic [ADDR_W-1:0] A_CPU  = ADDR_W'(ADDR_CPU_INT);

    logic unused_wdata_hi;
    assign unused_wdata_hi = ^wdata;

    // Status write strobes decoded from the address
    always_comb begin
        stat_wr  = wr_en && (addr == A_STAT);
        stat_set = wr_en && (addr == A_SET);
        stat_clr = wr_en && (addr == A_CLR);
    end

    // One configuration word per pin
    for (genvar i = 0; i < NPINS; i++) begin : g_cfg
        localparam logic [ADDR_W-1:0] A_CFG = ADDR_W'(CFG_BASE + i);
        pin_cfg_t cfg_q;

        // Configuration word storage
        always_ff @(posedge clk) begin
            if (!rst_n)                       cfg_q <= '0;
            else if (wr_en && addr == A_CFG)  cfg_q <= pin_cfg_t'(wdata[CFG_W-1:0]);
        end

        assign cfg_flat[i*CFG_W +: CFG_W] = cfg_q;
    end

    // Read multiplexer
    always_comb begin
        rdata = '0;
        case (addr)
            A_IN:    rdata = DATA_W'(in_val);
            A_STAT:  rdata = DATA_W'(status);
            A_RAW:   rdata = DATA_W'(raw);
            A_CPU:   rdata = DATA_W'(cpu_int);
            default: begin
                for (int i = 0; i < NPINS; i++) begin
                    if (addr == ADDR_W'(CFG_BASE + i))
                        rdata = DATA_W'(cfg_flat[i*CFG_W +: CFG_W]);
                end
            end
        endcase
    end

endmodule

// File: rtl/pin_event_unit.sv
// Top of the pin conditioner and interrupt detector.
// Each pin runs through two synchronizer stages into a detector. Status is
// gated into CPU interrupts, and live detections are gated into a wake request.
// Assumes NPINS <= DATA_W and CFG_BASE + NPINS fits in ADDR_W bits.
module pin_event_unit
    import pin_event_pkg::*;
#(
    parameter int NPINS  = 8,
    parameter int ADDR_W = 5,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NPINS-1:0]  pins_in,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [NPINS-1:0]  raw_event,
    output logic [NPINS-1:0]  cpu_int,
    output logic              irq,
    output logic              wake_req
);

    logic [NPINS*CFG_W-1:0] cfg_flat;
    logic [NPINS-1:0]       sync_val;
    logic [NPINS-1:0]       status;
    logic [NPINS-1:0]       wake_hit;
    logic                   stat_wr;
    logic                   stat_set;
    logic                   stat_clr;

    pin_event_regs #(
        .NPINS  (NPINS),
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .in_val   (sync_val),
        .status   (status),
        .raw      (raw_event),
        .cpu_int  (cpu_int),
        .cfg_flat (cfg_flat),
        .stat_wr  (stat_wr),
        .stat_set (stat_set),
        .stat_clr (stat_clr),
        .rdata    (reg_rdata)
    );

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        pin_cfg_t pcfg;
        logic     mid;

        assign pcfg = pin_cfg_t'(cfg_flat[i*CFG_W +: CFG_W]);

        pin_sync_stage u_stage1 (
            .clk   (clk),
            .rst_n (rst_n),
            .mode  (pcfg.stage1),
            .d     (pins_in[i]),
            .q     (mid)
        );

        pin_sync_stage u_stage2 (
            .clk   (clk),
            .rst_n (rst_n),
            .mode  (pcfg.stage2),
            .d     (mid),
            .q     (sync_val[i])
        );

        pin_detector u_det (
            .clk       (clk),
            .rst_n     (rst_n),
            .trig      (pcfg.trig),
            .cur       (sync_val[i]),
            .sw_wr     (stat_wr),
            .sw_wr_val (reg_wdata[i]),
            .sw_set    (stat_set & reg_wdata[i]),
            .sw_clr    (stat_clr & reg_wdata[i]),
            .raw       (raw_event[i]),
            .stat      (status[i])
        );

        // Per-pin interrupt and wake gating
        always_comb begin
            cpu_int[i]  = status[i] & pcfg.int_en;
            wake_hit[i] = raw_event[i] & pcfg.wake_en;
        end
    end

    // Collapse per-pin vectors into single request lines
    always_comb begin
        irq      = |cpu_int;
        wake_req = |wake_hit;
    end

    // R10
    irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (|status));

    // R11
    wake_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req |-> (|raw_event));

endmodule

// File: tb/pin_event_unit_test.sv
module pin_event_unit_test;
    localparam int NP = 8;
    localparam int AW = 5;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] pins = '0;
    logic          reg_wr = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic [NP-1:0] raw_event;
    logic [NP-1:0] cpu_int;
    logic          irq;
    logic          wake_req;

    int checks = 0;
    int fails = 0;

    always #4 clk = ~clk;

    pin_event_unit #(.NPINS(NP), .ADDR_W(AW), .DATA_W(DW)) uut (
        .clk(clk), .rst_n(rst_n), .pins_in(pins), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .raw_event(raw_event), .cpu_int(cpu_int), .irq(irq), .wake_req(wake_req)
    );

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic check(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic rd(input int a, output logic [DW-1:0] v);
        reg_addr = AW'(a);
        #1;
        v = reg_rdata;
    endtask

    task automatic wr(input int a, input logic [DW-1:0] d);
        reg_addr  = AW'(a);
        reg_wdata = d;
        reg_wr    = 1'b1;
        step();
        reg_wr    = 1'b0;
    endtask

    task automatic cfg(input int pin, input logic [DW-1:0] d);
        wr(8 + pin, d);
    endtask

    task automatic t_reset();
        logic [DW-1:0] v;
        rst_n = 1'b0;
        repeat (3) step();
        rst_n = 1'b1;
        step();
        rd(1, v); check("R1 status after reset", v, 0);
        rd(4, v); check("R1 raw after reset", v, 0);
        rd(5, v); check("R1 cpu_int after reset", v, 0);
        check("R1 irq/wake after reset", {30'd0, irq, wake_req}, 0);
        rd(8, v); check("R1 pin0 config after reset", v, 0);
        pins = 8'hA5;
        rd(0, v); check("R1 R3 bypass input view", v, 32'hA5);
        pins = '0;
        step();
    endtask

    task automatic t_sync_modes();
        logic [DW-1:0] v;
        cfg(0, 32'h0A);
        pins[0] = 1'b1;
        rd(0, v); check("R2 rise/rise edge 0", v & 1, 0);
        step(); rd(0, v); check("R2 rise/rise edge 1", v & 1, 0);
        step(); rd(0, v); check("R2 rise/rise edge 2", v & 1, 1);
        cfg(0, 32'h09);
        pins[0] = 1'b0;
        rd(0, v); check("R2 fall/rise before", v & 1, 1);
        step(); rd(0, v); check("R2 fall/rise one edge", v & 1, 0);
        cfg(0, 32'h0C);
        pins[0] = 1'b1;
        rd(0, v); check("R2 bypass/mode3 before", v & 1, 0);
        step(); rd(0, v); check("R2 bypass/mode3 one edge", v & 1, 1);
        cfg(0, 32'h04);
        pins[0] = 1'b0;
        rd(0, v); check("R2 bypass/fall before negedge", v & 1, 1);
        #2;
        rd(0, v); check("R2 bypass/fall after negedge", v & 1, 0);
        cfg(0, 32'h00);
    endtask

    task automatic t_edges();
        logic [DW-1:0] v;
        cfg(1, 32'h10);
        wr(1, 0);
        pins[1] = 1'b1;
        rd(4, v); check("R4 R7 rising raw", v, 32'h02);
        check("R7 raw port", {24'd0, raw_event}, 32'h02);
        step(); rd(1, v); check("R4 rising status", v, 32'h02);
        rd(4, v); check("R4 rising raw one cycle", v, 0);
        wr(3, 32'h02);
        pins[1] = 1'b0;
        rd(4, v); check("R4 rising ignores fall", v, 0);
        step(); rd(1, v); check("R4 rising status after fall", v, 0);
        cfg(1, 32'h20);
        pins[1] = 1'b1;
        rd(4, v); check("R4 falling ignores rise", v, 0);
        step();
        pins[1] = 1'b0;
        rd(4, v); check("R4 falling raw", v, 32'h02);
        step(); rd(1, v); check("R4 falling status", v, 32'h02);
        wr(3, 32'h02);
        cfg(1, 32'h30);
        pins[1] = 1'b1;
        rd(4, v); check("R4 any edge rise", v, 32'h02);
        step();
        pins[1] = 1'b0;
        rd(4, v); check("R4 any edge fall", v, 32'h02);
        step(); rd(1, v); check("R4 any edge status", v, 32'h02);
        wr(3, 32'h02);
        cfg(1, 32'h00);
    endtask

    task automatic t_levels();
        logic [DW-1:0] v;
        cfg(2, 32'h40);
        rd(4, v); check("R5 low level raw", v, 32'h04);
        step(); rd(1, v); check("R5 low level status", v, 32'h04);
        wr(3, 32'h04);
        rd(1, v); check("R5 R9 clear while low held", v, 32'h04);
        pins[2] = 1'b1;
        rd(4, v); check("R5 low level released", v, 0);
        wr(3, 32'h04);
        rd(1, v); check("R5 clear after release", v, 0);
        cfg(2, 32'h50);
        rd(4, v); check("R5 high level raw", v, 32'h04);
        step(); rd(1, v); check("R5 high level status", v, 32'h04);
        cfg(2, 32'h00);
        wr(3, 32'h04);
        rd(1, v); check("R5 cleared after disable", v, 0);
        pins[2] = 1'b0;
        step();
    endtask

    task automatic t_disabled();
        logic [DW-1:0] v;
        for (int k = 0; k < 3; k++) begin
            logic [DW-1:0] t;
            t = (k == 0) ? 32'h60 : (k == 1) ? 32'h70 : 32'h00;
            cfg(3, t);
            pins[3] = 1'b1;
            rd(4, v); check("R6 no raw on rise", v, 0);
            step();
            pins[3] = 1'b0;
            rd(4, v); check("R6 no raw on fall", v, 0);
            step(); rd(1, v); check("R6 status untouched", v, 0);
        end
        cfg(3, 32'h00);
    endtask

    task automatic t_sw_status();
        logic [DW-1:0] v;
        wr(2, 32'h30); rd(1, v); check("R8 set alias", v, 32'h30);
        wr(3, 32'h10); rd(1, v); check("R8 clear alias", v, 32'h20);
        wr(1, 32'h81); rd(1, v); check("R8 direct write", v, 32'h81);
        wr(1, 32'h40); wr(2, 32'h01);
        rd(1, v); check("R8 set keeps zero-written bits", v, 32'h41);
        wr(3, 32'hFF); rd(1, v); check("R8 clear all", v, 0);
    endtask

    task automatic t_collision();
        logic [DW-1:0] v;
        cfg(4, 32'h10);
        wr(2, 32'h10);
        pins[4]   = 1'b1;
        reg_addr  = AW'(3);
        reg_wdata = 32'h10;
        reg_wr    = 1'b1;
        step();
        reg_wr    = 1'b0;
        rd(1, v); check("R9 edge beats clear alias", v, 32'h10);
        wr(3, 32'h10); rd(1, v); check("R9 clear once edge gone", v, 0);
        pins[4] = 1'b0;
        cfg(4, 32'h20);
        pins[4] = 1'b1;
        step();
        pins[4]   = 1'b0;
        reg_addr  = AW'(1);
        reg_wdata = 32'h0;
        reg_wr    = 1'b1;
        step();
        reg_wr    = 1'b0;
        rd(1, v); check("R9 edge beats direct write", v, 32'h10);
        wr(3, 32'h10);
        cfg(4, 32'h00);
    endtask

    task automatic t_cpu_int();
        logic [DW-1:0] v;
        wr(2, 32'h20);
        rd(5, v); check("R10 masked cpu_int", v, 0);
        check("R10 irq masked", {31'd0, irq}, 0);
        cfg(5, 32'h80);
        rd(5, v); check("R10 cpu_int register", v, 32'h20);
        check("R10 cpu_int port", {24'd0, cpu_int}, 32'h20);
        check("R10 irq on", {31'd0, irq}, 1);
        cfg(6, 32'h80);
        rd(5, v); check("R10 enable without status", v, 32'h20);
        wr(3, 32'h20);
        rd(5, v); check("R10 cpu_int cleared", v, 0);
        check("R10 irq off", {31'd0, irq}, 0);
        cfg(5, 32'h00);
        cfg(6, 32'h00);
    endtask

    task automatic t_wake();
        logic [DW-1:0] v;
        cfg(6, 32'h50);
        pins[6] = 1'b1;
        #1;
        check("R11 raw without wake enable", {24'd0, raw_event}, 32'h40);
        check("R11 wake masked", {31'd0, wake_req}, 0);
        cfg(6, 32'h150);
        rd(14, v); check("R12 config readback", v, 32'h150);
        check("R11 wake on", {31'd0, wake_req}, 1);
        check("R10 irq unaffected by wake", {31'd0, irq}, 0);
        pins[6] = 1'b0;
        #1;
        check("R11 wake follows level", {31'd0, wake_req}, 0);
        cfg(6, 32'h00);
        wr(1, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_sync_modes();
        t_edges();
        t_levels();
        t_disabled();
        t_sw_status();
        t_collision();
        t_cpu_int();
        t_wake();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule